// File: doc/BRIEF.md
# Direct-Mapped Byte Load Cache

This block is a small blocking cache for reads only. It sits between a processor that issues byte loads and a slower backing memory that returns whole two-byte blocks. Each 5-bit byte address is cut into three fields: a tag, a line index and a byte offset. The cache holds one line for each index. Each line carries a valid flag, a stored tag and a two-byte block.

A load that finds its line valid, with a matching tag, returns its byte on the next cycle. A load that misses raises a refill request for the aligned block and stalls the processor port. When the memory replies, the block overwrites the indexed line and the requested byte is returned. There is no choice of victim: the index alone names the line to replace. Two running counters record hits and misses, so a trace that thrashes on conflicting lines can be checked by its exact totals.

The load port uses valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request inputs are ignored and the caller must hold or retry. The response is a single-cycle `rsp_valid` pulse with no back-pressure. The refill port holds `mem_req_valid` and its address steady until the memory answers with a one-cycle `mem_rsp_valid`.

Top module: `dm_read_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.
- R2: The address fields are tag = addr[4:3], index = addr[2:1] and offset = addr[0]. The line used is the block number addr[4:1] modulo 4.
- R3: An accepted load hits when the indexed line is valid and its tag equals the address tag. Its byte appears with `rsp_valid` one cycle after acceptance, and no refill request is raised.
- R4: The offset picks the byte within the block. Offset 0 returns block bits [7:0] and offset 1 returns bits [15:8]. This holds for data from a hit and for data from a refill.
- R5: On a miss, `mem_req_valid` rises the cycle after acceptance and carries the block address addr[4:1]. Both stay steady until `mem_rsp_valid`. The requested byte is then returned the cycle after `mem_rsp_valid`.
- R6: `req_ready` is low from the cycle after a miss is accepted until the cycle after the refill data arrives. Requests presented while it is low are ignored.
- R7: Each accepted hit adds one to `hit_count` and each accepted miss adds one to `miss_count`.
- R8: A refill overwrites the indexed line. Loads that alternate between two addresses with the same index and different tags therefore miss every time.
- R9: Every accepted load produces exactly one `rsp_valid` pulse, and no pulse appears without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Cache can take a request (low = stall) |
| req_addr | input | 5 | Byte address of the load |
| rsp_valid | output | 1 | One-cycle pulse with returned byte |
| rsp_data | output | 8 | Returned byte |
| mem_req_valid | output | 1 | Refill request pending |
| mem_req_addr | output | 4 | Block address of the refill |
| mem_rsp_valid | input | 1 | Refill data present (one cycle) |
| mem_rsp_data | input | 16 | Refill block, byte 0 in bits [7:0] |
| hit_count | output | 16 | Running count of hits |
| miss_count | output | 16 | Running count of misses |

## Verification
The hardest case to reach from the ports is a request that arrives while a refill is still in flight. To create it, the bench starts a miss against a memory model with a fixed multi-cycle latency, then drives `req_valid` with a different address during the stall. It then checks that the counters and the response count move only for the original load. The conflict case is reached by alternating addresses 12 and 5, which share an index. A sweep over all 32 addresses, in two orders, is compared against a hit prediction that the bench derives from the field split.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);
  assign off = addr[OFF_W-1:0];
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 2,
  parameter int BLK_W = 16,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [BLK_W-1:0] lk_block,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [BLK_W-1:0] fill_block
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0] blk_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        blk_q[g] <= '0;
      end else if (fill_we && fill_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= fill_tag;
        blk_q[g] <= fill_block;
      end
    end
  end

  assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_block = blk_q[lk_idx];

  // R8: a refilled line is valid and holds the new tag afterwards
  assert_fill_installs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (vld_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int BLK_W = DATA_W << OFF_W,
  localparam int NBYTE = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  rq_tag,
  input  logic [IDX_W-1:0]  rq_idx,
  input  logic [OFF_W-1:0]  rq_off,
  input  logic              lk_hit,
  input  logic [BLK_W-1:0]  lk_block,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [TAG_W+IDX_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [BLK_W-1:0]  mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  dmc_state_e       state_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [OFF_W-1:0] pend_off_q;
  logic             accept;

  function automatic logic [DATA_W-1:0] pick_byte(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] off);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < NBYTE; b++)
      if (off == OFF_W'(b)) r = blk[b*DATA_W +: DATA_W];
    return r;
  endfunction

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_FILL);
  assign mem_req_addr  = {pend_tag_q, pend_idx_q};
  assign fill_we       = (state_q == ST_FILL) && mem_rsp_valid;
  assign fill_idx      = pend_idx_q;
  assign fill_tag      = pend_tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_tag_q <= '0;
      pend_idx_q <= '0;
      pend_off_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (lk_hit) begin
            hit_count <= hit_count + 1'b1;
            rsp_valid <= 1'b1;
            rsp_data  <= pick_byte(lk_block, rq_off);
          end else begin
            miss_count <= miss_count + 1'b1;
            pend_tag_q <= rq_tag;
            pend_idx_q <= rq_idx;
            pend_off_q <= rq_off;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_data  <= pick_byte(mem_rsp_data, pend_off_q);
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] total;
  assign total = {1'b0, hit_count} + {1'b0, miss_count};

  assert_miss_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit) |=> (mem_req_valid && !req_ready));
  assert_refill_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_hit_responds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit) |=> (rsp_valid && !mem_req_valid));
  assert_refill_responds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid) |=> (rsp_valid && req_ready));
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (total == $past(total) + 1'b1));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (total == $past(total)));
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W = DATA_W << OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    mem_req_valid,
  output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [BLK_W-1:0]        mem_rsp_data,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);
  logic [TAG_W-1:0] rq_tag, fill_tag;
  logic [IDX_W-1:0] rq_idx, fill_idx;
  logic [OFF_W-1:0] rq_off;
  logic             lk_hit, fill_we;
  logic [BLK_W-1:0] lk_block;

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr(req_addr), .tag(rq_tag), .idx(rq_idx), .off(rq_off));

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(rq_idx), .lk_tag(rq_tag), .lk_hit(lk_hit), .lk_block(lk_block),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_block(mem_rsp_data));

  dmc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
             .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rq_tag(rq_tag), .rq_idx(rq_idx), .rq_off(rq_off),
    .lk_hit(lk_hit), .lk_block(lk_block),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count));

  // R1: nothing is pending or returned straight after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!rsp_valid && !mem_req_valid && req_ready));
endmodule

// File: tb/sim_dm_read_cache.sv
module sim_dm_read_cache;
  localparam int LAT = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_rsp_valid = 1'b0;
  logic [4:0] req_addr = '0;
  logic [15:0] mem_rsp_data = '0;
  logic req_ready, rsp_valid, mem_req_valid;
  logic [7:0] rsp_data;
  logic [3:0] mem_req_addr;
  logic [15:0] hit_count, miss_count;
  int checks = 0, fails = 0, refills = 0, pulses = 0;
  logic [3:0] exp_blk;
  logic mv [4];
  logic [1:0] mt [4];
  int eh = 0, em = 0;

  always #5 clk = ~clk;

  dm_read_cache u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic [7:0] mbyte(input int a);
    return 8'((a * 10 + 100) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: fixed latency, block byte 0 in bits [7:0]
  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      chk(mem_req_addr == exp_blk, "R5 refill address", mem_req_addr, exp_blk);
      repeat (LAT) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data = {mbyte(2*mem_req_addr+1), mbyte(2*mem_req_addr)};
      refills++;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
  end

  always @(posedge clk) if (rst_n && rsp_valid) pulses++;

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) mv[i] = 1'b0;
    eh = 0; em = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset", req_ready, 1);
    chk(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count + miss_count, 0);
  endtask

  // one load; expected hit derived from the tag/index/offset split (R2)
  task automatic load(input int a, input string tagname);
    int idx, tg, cyc, p0;
    bit eh_hit;
    idx = (a >> 1) & 3; tg = a >> 3;
    eh_hit = mv[idx] && mt[idx] == 2'(tg);
    exp_blk = 4'(a >> 1);
    p0 = pulses;
    req_valid = 1'b1; req_addr = 5'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 50) begin @(negedge clk); cyc++; end
    if (eh_hit) begin
      eh++;
      chk(cyc == 0, {"R3 hit latency ", tagname}, cyc, 0);
    end else begin
      em++;
      chk(cyc == LAT + 1, {"R5 miss latency ", tagname}, cyc, LAT + 1);
    end
    chk(rsp_data == mbyte(a), {"R4 byte ", tagname}, rsp_data, mbyte(a));
    mv[idx] = 1'b1; mt[idx] = 2'(tg);
    @(negedge clk);
    chk(!rsp_valid && pulses == p0 + 1, {"R9 single pulse ", tagname}, pulses - p0, 1);
    chk(hit_count == eh && miss_count == em, {"R7 counters ", tagname}, hit_count, eh);
  endtask

  initial begin
    do_reset();
    // reference trace: miss miss hit hit hit
    load(1, "t1"); load(5, "t5"); load(1, "t1b"); load(4, "t4"); load(0, "t0");
    chk(hit_count == 3 && miss_count == 2, "R3 trace totals", hit_count, 3);
    // R8 conflict thrash between 12 and 5 (same index 2)
    for (int k = 0; k < 4; k++) begin load(12, "c12"); load(5, "c5"); end
    chk(miss_count == 10 && hit_count == 3, "R8 thrash misses", miss_count, 10);
    // R6 requests during a stall are ignored
    begin
      int r0, p0;
      r0 = refills; p0 = pulses;
      exp_blk = 4'(20 >> 1);
      req_valid = 1'b1; req_addr = 5'd20;
      @(negedge clk);
      chk(!req_ready, "R6 stall asserted", req_ready, 0);
      req_addr = 5'd1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk(rsp_data == mbyte(20), "R6 original byte", rsp_data, mbyte(20));
      @(negedge clk);
      chk(miss_count == 11 && hit_count == 3, "R6 ignored request", miss_count, 11);
      chk(pulses == p0 + 1 && refills == r0 + 1, "R6 one response", pulses - p0, 1);
      mv[2] = 1'b1; mt[2] = 2'd2;
      em = 11; eh = 3;
    end
    // R1 reset invalidates lines
    do_reset();
    load(0, "r1 after reset");
    chk(miss_count == 1, "R1 lines invalid", miss_count, 1);
    // R2 sweep over every address in two orders
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < 32; i++)
        load((i * 7 + pass * 3) % 32, "R2 sweep");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule